// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a 32-bit virtual address into a 30-bit physical address by fetching one descriptor from a flat, single-level translation table in memory. A TLB hands it a virtual address on a request port. The walker adds the virtual page number, scaled to 4-byte descriptors, to a table base register and issues one memory read. It then waits for the memory to answer. If the descriptor is marked present, it returns the physical page number joined to the untouched 12-bit page offset. If not, it raises a page fault and keeps the faulting virtual address for the handler.

The table base register belongs to the current process. It can always be read. It can be changed only when the supervisor-mode input is high. A write attempted from user mode is dropped and reported on a privilege-error output. Only one walk is in flight at a time.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `req_ready_o` is 1, `mem_rd_req_o`, `rsp_done_o`, `fault_o` and `priv_err_o` are 0, and `base_o` and `fault_vaddr_o` are 0.
- R2: A request is taken only when `req_ready_o` is 1, which happens only while idle. On the edge that takes it, `mem_rd_req_o` goes to 1 and `req_ready_o` goes to 0.
- R3: The read address is `base + (vaddr[31:12] * 4)`, taken modulo 2^32, using the base value present on the accepting edge.
- R4: `mem_rd_req_o` stays 1 and `mem_rd_addr_o` stays unchanged until an edge on which `mem_rd_valid_i` is 1. After that edge `mem_rd_req_o` is 0.
- R5: If bit 31 (present) of the returned descriptor is 1, `rsp_done_o` is 1 in the cycle after the edge that sampled `mem_rd_valid_i`. In that cycle `rsp_paddr_o = {desc[17:0], vaddr[11:0]}`, `rsp_dirty_o = desc[30]` and `rsp_wr_en_o = desc[29]`. Descriptor bits 28:18 have no effect.
- R6: If bit 31 is 0, `fault_o` is 1 in that same cycle and `fault_vaddr_o` takes the full 32-bit virtual address. `fault_vaddr_o` keeps that value until the next fault.
- R7: `rsp_done_o` and `fault_o` each last one cycle and are never 1 together.
- R8: A write (`base_wr_i`=1) with `sup_mode_i`=1 loads `base_wr_data_i` into `base_o` on that edge, and `priv_err_o` stays 0.
- R9: A write with `sup_mode_i`=0 leaves `base_o` unchanged and pulses `priv_err_o` for exactly one cycle after the edge.
- R10: A base write made during a walk does not change the read address of that walk.
- R11: A request presented while a walk is in progress is dropped. It is not queued, and it starts no read after the walk ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Translation request |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_ready_o | output | 1 | Walker idle, request will be taken |
| rsp_done_o | output | 1 | One-cycle pulse: translation succeeded |
| rsp_paddr_o | output | 30 | Physical address, valid with done |
| rsp_dirty_o | output | 1 | Dirty flag from the descriptor |
| rsp_wr_en_o | output | 1 | Write-enable flag from the descriptor |
| fault_o | output | 1 | One-cycle pulse: page not present |
| fault_vaddr_o | output | 32 | Virtual address of the last fault |
| mem_rd_req_o | output | 1 | Memory read request, held until answered |
| mem_rd_addr_o | output | 32 | Descriptor byte address |
| mem_rd_valid_i | input | 1 | Memory read data valid |
| mem_rd_data_i | input | 32 | Descriptor read from memory |
| sup_mode_i | input | 1 | Supervisor mode |
| base_wr_i | input | 1 | Base register write strobe |
| base_wr_data_i | input | 32 | Base register write value |
| base_o | output | 32 | Current table base |
| priv_err_o | output | 1 | One-cycle pulse: base write refused |

## Verification
Translations are swept over several table bases, including one near the top of the address space so the descriptor address wraps. Page numbers at zero, one, mid-range and all ones are checked alongside this: they separate a correct scale-and-add from a missing shift or a carry lost at bit 31. Each walk uses descriptors with and without the present bit, with the dirty and write flags set in different combinations, and with junk in the unused middle bits. These show that each flag comes from its own bit position and that the physical page number is not polluted. Memory latency varies from zero to three wait cycles. During the waits, competing requests and supervisor base writes are injected, which tells a held, latched walk apart from one that re-samples its inputs.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } walk_st_e;
endpackage

// File: rtl/ptw_base_reg.sv
module ptw_base_reg #(
  parameter int          VA_W       = 32,
  parameter logic [31:0] BASE_RESET = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sup_mode_i,
  input  logic            base_wr_i,
  input  logic [VA_W-1:0] base_wr_data_i,
  output logic [VA_W-1:0] base_o,
  output logic            priv_err_o
);
  logic [VA_W-1:0] base_q;
  logic            err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= BASE_RESET[VA_W-1:0];
      err_q  <= 1'b0;
    end else begin
      err_q <= base_wr_i && !sup_mode_i;
      if (base_wr_i && sup_mode_i) base_q <= base_wr_data_i;
    end
  end

  assign base_o     = base_q;
  assign priv_err_o = err_q;

  assert_sup_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_wr_i && sup_mode_i) |=> (base_o == $past(base_wr_data_i) && !priv_err_o));

  assert_user_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_wr_i && !sup_mode_i) |=> ($stable(base_o) && priv_err_o));

  assert_err_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_err_o && !(base_wr_i && !sup_mode_i)) |=> !priv_err_o);
endmodule

// File: rtl/ptw_desc_decode.sv
module ptw_desc_decode #(
  parameter int PTE_W  = 32,
  parameter int PPN_W  = 18,
  parameter int V_BIT  = 31,
  parameter int D_BIT  = 30,
  parameter int WE_BIT = 29
) (
  input  logic [PTE_W-1:0] desc_i,
  output logic             present_o,
  output logic             dirty_o,
  output logic             wr_en_o,
  output logic [PPN_W-1:0] ppn_o
);
  assign present_o = desc_i[V_BIT];
  assign dirty_o   = desc_i[D_BIT];
  assign wr_en_o   = desc_i[WE_BIT];
  assign ppn_o     = desc_i[PPN_W-1:0];
endmodule

// File: rtl/ptw_walk_fsm.sv
module ptw_walk_fsm
  import ptw_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int OFF_W  = 12,
  parameter int PPN_W  = 18,
  parameter int PTE_W  = 32,
  parameter int IDX_SH = 2,
  parameter int V_BIT  = 31,
  parameter int D_BIT  = 30,
  parameter int WE_BIT = 29,
  localparam int PA_W  = PPN_W + OFF_W,
  localparam int VPN_W = VA_W - OFF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  req_vaddr_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  base_i,
  output logic             mem_rd_req_o,
  output logic [VA_W-1:0]  mem_rd_addr_o,
  input  logic             mem_rd_valid_i,
  input  logic [PTE_W-1:0] mem_rd_data_i,
  output logic             rsp_done_o,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic             rsp_dirty_o,
  output logic             rsp_wr_en_o,
  output logic             fault_o,
  output logic [VA_W-1:0]  fault_vaddr_o
);
  walk_st_e         st_q;
  logic [VA_W-1:0]  vaddr_q, addr_q, epc_q;
  logic [PA_W-1:0]  paddr_q;
  logic             done_q, fault_q, dirty_q, wr_en_q;
  logic [VPN_W-1:0] req_vpn;
  logic [VA_W-1:0]  desc_off;
  logic             d_present, d_dirty, d_wr_en;
  logic [PPN_W-1:0] d_ppn;

  assign req_vpn  = req_vaddr_i[VA_W-1:OFF_W];
  assign desc_off = VA_W'(req_vpn) << IDX_SH;

  ptw_desc_decode #(
    .PTE_W(PTE_W), .PPN_W(PPN_W), .V_BIT(V_BIT), .D_BIT(D_BIT), .WE_BIT(WE_BIT)
  ) u_decode (
    .desc_i   (mem_rd_data_i),
    .present_o(d_present),
    .dirty_o  (d_dirty),
    .wr_en_o  (d_wr_en),
    .ppn_o    (d_ppn)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      vaddr_q <= '0;
      addr_q  <= '0;
      epc_q   <= '0;
      paddr_q <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      dirty_q <= 1'b0;
      wr_en_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            vaddr_q <= req_vaddr_i;
            addr_q  <= base_i + desc_off;  // base frozen for this walk
            st_q    <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (mem_rd_valid_i) begin
            st_q <= ST_IDLE;
            if (d_present) begin
              done_q  <= 1'b1;
              paddr_q <= {d_ppn, vaddr_q[OFF_W-1:0]};
              dirty_q <= d_dirty;
              wr_en_q <= d_wr_en;
            end else begin
              fault_q <= 1'b1;
              epc_q   <= vaddr_q;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o   = (st_q == ST_IDLE);
  assign mem_rd_req_o  = (st_q == ST_WAIT);
  assign mem_rd_addr_o = addr_q;
  assign rsp_done_o    = done_q;
  assign rsp_paddr_o   = paddr_q;
  assign rsp_dirty_o   = dirty_q;
  assign rsp_wr_en_o   = wr_en_q;
  assign fault_o       = fault_q;
  assign fault_vaddr_o = epc_q;

  assert_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (mem_rd_req_o && !req_ready_o));

  assert_hold_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_req_o && !mem_rd_valid_i) |=> (mem_rd_req_o && $stable(mem_rd_addr_o)));

  assert_read_ends_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_req_o && mem_rd_valid_i) |=> (!mem_rd_req_o && (rsp_done_o || fault_o)));

  assert_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_done_o && fault_o));

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |=> !rsp_done_o);

  assert_fault_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> !fault_o);

  assert_epc_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_o |=> (fault_o || $stable(fault_vaddr_o)));
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int          VA_W       = 32,
  parameter int          OFF_W      = 12,
  parameter int          PPN_W      = 18,
  parameter int          PTE_W      = 32,
  parameter int          PTE_BYTES  = 4,
  parameter logic [31:0] BASE_RESET = '0,
  localparam int         PA_W       = PPN_W + OFF_W,
  localparam int         IDX_SH     = $clog2(PTE_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  req_vaddr_i,
  output logic             req_ready_o,
  output logic             rsp_done_o,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic             rsp_dirty_o,
  output logic             rsp_wr_en_o,
  output logic             fault_o,
  output logic [VA_W-1:0]  fault_vaddr_o,
  output logic             mem_rd_req_o,
  output logic [VA_W-1:0]  mem_rd_addr_o,
  input  logic             mem_rd_valid_i,
  input  logic [PTE_W-1:0] mem_rd_data_i,
  input  logic             sup_mode_i,
  input  logic             base_wr_i,
  input  logic [VA_W-1:0]  base_wr_data_i,
  output logic [VA_W-1:0]  base_o,
  output logic             priv_err_o
);
  logic [VA_W-1:0] base_w;

  ptw_base_reg #(.VA_W(VA_W), .BASE_RESET(BASE_RESET)) u_base (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sup_mode_i    (sup_mode_i),
    .base_wr_i     (base_wr_i),
    .base_wr_data_i(base_wr_data_i),
    .base_o        (base_w),
    .priv_err_o    (priv_err_o)
  );

  ptw_walk_fsm #(
    .VA_W(VA_W), .OFF_W(OFF_W), .PPN_W(PPN_W), .PTE_W(PTE_W), .IDX_SH(IDX_SH),
    .V_BIT(PTE_W-1), .D_BIT(PTE_W-2), .WE_BIT(PTE_W-3)
  ) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_vaddr_i   (req_vaddr_i),
    .req_ready_o   (req_ready_o),
    .base_i        (base_w),
    .mem_rd_req_o  (mem_rd_req_o),
    .mem_rd_addr_o (mem_rd_addr_o),
    .mem_rd_valid_i(mem_rd_valid_i),
    .mem_rd_data_i (mem_rd_data_i),
    .rsp_done_o    (rsp_done_o),
    .rsp_paddr_o   (rsp_paddr_o),
    .rsp_dirty_o   (rsp_dirty_o),
    .rsp_wr_en_o   (rsp_wr_en_o),
    .fault_o       (fault_o),
    .fault_vaddr_o (fault_vaddr_o)
  );

  assign base_o = base_w;

  assert_no_read_when_ready_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_ready_o && mem_rd_req_o));
endmodule

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready;
  logic        rsp_done;
  logic [29:0] rsp_paddr;
  logic        rsp_dirty, rsp_wr_en;
  logic        fault;
  logic [31:0] fault_vaddr;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        sup_mode = 1'b0;
  logic        base_wr = 1'b0;
  logic [31:0] base_wdata = '0;
  logic [31:0] base_out;
  logic        priv_err;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [31:0] base_model = '0;
  logic [31:0] epc_model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_walker dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_vaddr_i(req_vaddr), .req_ready_o(req_ready),
    .rsp_done_o(rsp_done), .rsp_paddr_o(rsp_paddr), .rsp_dirty_o(rsp_dirty),
    .rsp_wr_en_o(rsp_wr_en), .fault_o(fault), .fault_vaddr_o(fault_vaddr),
    .mem_rd_req_o(mem_rd_req), .mem_rd_addr_o(mem_rd_addr),
    .mem_rd_valid_i(mem_rd_valid), .mem_rd_data_i(mem_rd_data),
    .sup_mode_i(sup_mode), .base_wr_i(base_wr), .base_wr_data_i(base_wdata),
    .base_o(base_out), .priv_err_o(priv_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  task automatic write_base(input logic [31:0] v, input bit sup);
    @(negedge clk);
    base_wr = 1; sup_mode = sup; base_wdata = v;
    @(negedge clk);
    base_wr = 0; sup_mode = 0;
    if (sup) begin
      base_model = v;
      chk(base_out == v, "R8 base load", base_out, v);
      chk(priv_err == 0, "R8 no error", {31'd0, priv_err}, 0);
    end else begin
      chk(base_out == base_model, "R9 base kept", base_out, base_model);
      chk(priv_err == 1, "R9 error pulse", {31'd0, priv_err}, 1);
      @(negedge clk);
      chk(priv_err == 0, "R9 error one cycle", {31'd0, priv_err}, 0);
    end
  endtask

  task automatic walk(input logic [31:0] va, input logic [31:0] desc, input int lat, input bit wr_mid);
    logic [31:0] exp_addr;
    logic [29:0] exp_pa;
    logic [31:0] new_base;
    exp_addr = base_model + {va[31:12], 2'b00};
    exp_pa   = {desc[17:0], va[11:0]};
    new_base = base_model ^ 32'h00A0_1000;
    @(negedge clk);
    chk(req_ready == 1, "R2 idle ready", {31'd0, req_ready}, 1);
    req_valid = 1; req_vaddr = va;
    @(negedge clk);
    req_valid = 0;
    chk(mem_rd_req == 1, "R2 read issued", {31'd0, mem_rd_req}, 1);
    chk(req_ready == 0, "R2 busy", {31'd0, req_ready}, 0);
    chk(mem_rd_addr == exp_addr, "R3 descriptor address", mem_rd_addr, exp_addr);
    for (int k = 0; k < lat; k++) begin
      if (k == 0) begin
        req_valid = 1; req_vaddr = ~va;  // R11 competing request
        if (wr_mid) begin base_wr = 1; sup_mode = 1; base_wdata = new_base; end
      end
      @(negedge clk);
      req_valid = 0; base_wr = 0; sup_mode = 0;
      if (k == 0 && wr_mid) base_model = new_base;
      chk(mem_rd_req == 1, "R4 read held", {31'd0, mem_rd_req}, 1);
      chk(mem_rd_addr == exp_addr, "R4/R10 address stable", mem_rd_addr, exp_addr);
    end
    mem_rd_valid = 1; mem_rd_data = desc;
    @(negedge clk);
    mem_rd_valid = 0; mem_rd_data = 32'hDEAD_BEEF;
    chk(mem_rd_req == 0, "R4 read ends", {31'd0, mem_rd_req}, 0);
    if (desc[31]) begin
      chk(rsp_done == 1 && fault == 0, "R5 done", {30'd0, rsp_done, fault}, 32'd2);
      chk(rsp_paddr == exp_pa, "R5 paddr", {2'b0, rsp_paddr}, {2'b0, exp_pa});
      chk(rsp_dirty == desc[30] && rsp_wr_en == desc[29], "R5 flags",
          {30'd0, rsp_dirty, rsp_wr_en}, {30'd0, desc[30], desc[29]});
      chk(fault_vaddr == epc_model, "R6 fault address held", fault_vaddr, epc_model);
    end else begin
      epc_model = va;
      chk(fault == 1 && rsp_done == 0, "R6 fault", {30'd0, rsp_done, fault}, 32'd1);
      chk(fault_vaddr == va, "R6 fault address", fault_vaddr, va);
    end
    @(negedge clk);
    chk(rsp_done == 0 && fault == 0, "R7 single-cycle pulse", {30'd0, rsp_done, fault}, 0);
    chk(mem_rd_req == 0, "R11 dropped request not started", {31'd0, mem_rd_req}, 0);
    chk(fault_vaddr == epc_model, "R6 fault address kept", fault_vaddr, epc_model);
    if (wr_mid) chk(base_out == base_model, "R10 base updated after walk", base_out, base_model);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] bases [4];
    logic [19:0] vpns [5];
    int idx;
    bases[0] = 32'h0000_0000; bases[1] = 32'h0040_0000;
    bases[2] = 32'hFFFF_F000; bases[3] = 32'h1234_5678;
    vpns[0] = 20'h00000; vpns[1] = 20'h00001; vpns[2] = 20'h80000;
    vpns[3] = 20'hFFFFF; vpns[4] = 20'h5A5A5;

    repeat (3) @(negedge clk);
    chk(req_ready == 1, "R1 ready", {31'd0, req_ready}, 1);
    chk(mem_rd_req == 0 && rsp_done == 0 && fault == 0 && priv_err == 0, "R1 outputs idle",
        {28'd0, mem_rd_req, rsp_done, fault, priv_err}, 0);
    chk(base_out == 0, "R1 base", base_out, 0);
    chk(fault_vaddr == 0, "R1 fault address", fault_vaddr, 0);
    rst_n = 1;

    write_base(32'h0000_2000, 1'b0);  // user write refused
    idx = 0;
    for (int b = 0; b < 4; b++) begin
      write_base(bases[b], 1'b1);
      write_base(~bases[b], 1'b0);
      for (int v = 0; v < 5; v++) begin
        for (int p = 0; p < 2; p++) begin
          logic [31:0] va;
          logic [31:0] desc;
          va = {vpns[v], 12'(32'h0A5 * (idx + 1))};
          desc = {p[0] ? 1'b1 : 1'b0, idx[0], idx[1], 11'(32'h5A3 ^ idx), 18'(32'h2C4B1 * (idx + 3))};
          if (v == 3) desc[17:0] = 18'h3FFFF;
          walk(va, desc, idx % 4, (idx % 7) == 3);
          idx++;
        end
      end
    end
    finish_run();
  end
endmodule